// File: doc/BRIEF.md
# External Event Counter Watchdog

This block counts rising edges of an external event input that may be asynchronous to the system clock. Software programs a period and enables the counter. The counter then waits for the first event edge. That edge loads it with the all-ones value minus the period. Every later edge adds one. When the count reaches the value one below all-ones, a sticky interrupt latch is set. The edge after that reloads the counter from the period, so the cycle repeats with a fixed number of events between interrupts.

Used as a watchdog, software restarts the sequence by disabling and re-enabling the block before the count reaches the top. A disabled counter holds its value so that it can be read coherently. The interrupt latch stays set until a write-one-to-clear strobe removes it. The event input passes through a synchronizer in the system clock domain before edge detection.

Top module: `ext_event_wdt`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) count_o is 0, irq_o is 0 and the block is disabled, so event edges change nothing.
- R2: After an enable strobe, count_o holds its value until the first detected rising edge of event_in. That edge loads count_o with all-ones minus period_i (0xFFFFFFFF - period_i at the default 32-bit width).
- R3: Each later detected rising edge, while the count is below 0xFFFFFFFE, increments count_o by exactly one.
- R4: irq_o is set at the edge on which count_o becomes 0xFFFFFFFE. This includes a first-edge load that lands there directly (period_i = 1).
- R5: The detected rising edge that follows a count of 0xFFFFFFFE reloads count_o with all-ones minus period_i.
- R6: A disable strobe stops the counter. count_o then keeps its value, and event edges are ignored until the next enable.
- R7: An enable strobe, whether the counter is disabled or running, restarts the sequence. The counter again waits for a first edge and reloads from period_i, which services the watchdog.
- R8: An enable strobe and a disable strobe in the same cycle leave the block disabled.
- R9: irq_o is sticky and falls only on an irq_clr strobe. If a set and a clear fall in the same cycle, the set wins and irq_o stays 1.
- R10: event_in passes through a two-flop synchronizer. A high phase of at least two clocks, followed by a low phase of at least two clocks, counts as exactly one event, however long the high phase lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| event_in | input | 1 | External event input, asynchronous |
| period_i | input | 32 | Number of events per interrupt interval |
| enable_set | input | 1 | One-cycle strobe: enable and restart |
| disable_set | input | 1 | One-cycle strobe: stop and hold count |
| irq_clr | input | 1 | One-cycle write-one-to-clear strobe for the interrupt latch |
| irq_o | output | 1 | Sticky interrupt latch |
| count_o | output | 32 | Current counter value |

## Verification
The bench builds the block with its default parameters: a 32-bit counter and two synchronizer stages. Because the first edge loads near the top of the range, small periods of 1 to 8 bring the 0xFFFFFFFE boundary, the reload and the interrupt within a few events. The synchronizer depth of two fixes the latency from an input rise to the count update at three clock edges. The bench relies on that latency when it lines up a clear strobe with an interrupt set, and when it places samples.

// File: rtl/ewd_pkg.sv
// Package: shared types for the external event counter watchdog.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package ewd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ewd_state_t;
endpackage

// File: rtl/ewd_sync.sv
// Module: ewd_sync
// Brings an asynchronous level into the clock domain through STAGES flops
// and emits a one-cycle pulse on each rising transition.
// Assumes the input holds each level for at least STAGES clocks.
module ewd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], async_i};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R10
endmodule

// File: rtl/ewd_ctrl.sv
// Module: ewd_ctrl
// Enable state machine: idle, armed (waiting for the first edge), running.
// Decides on each detected edge whether the counter loads or increments.
// Assumes strobes are single-cycle; disable dominates enable.
module ewd_ctrl
    import ewd_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_set,
    input  logic             disable_set,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] cnt_i,
    output ewd_state_t       state_o,
    output logic             load_o,
    output logic             incr_o
);
    localparam logic [CNT_W-1:0] TOP = {{(CNT_W-1){1'b1}}, 1'b0};

    ewd_state_t state_q;
    logic       quiet;
    logic       at_top;

    assign quiet  = !enable_set && !disable_set;
    assign at_top = (cnt_i >= TOP);

    // Advance the enable state on strobes and on the first edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    state_q <= ST_IDLE;
        else if (disable_set)          state_q <= ST_IDLE;
        else if (enable_set)           state_q <= ST_ARMED;
        else if (state_q == ST_ARMED && rise_i) state_q <= ST_RUN;
    end

    // Derive the counter actions for this cycle.
    always_comb begin
        load_o = 1'b0;
        incr_o = 1'b0;
        if (quiet && rise_i) begin
            if (state_q == ST_ARMED)    load_o = 1'b1;
            else if (state_q == ST_RUN) begin
                load_o = at_top;
                incr_o = !at_top;
            end
        end
    end

    assign state_o = state_q;

    AST_ACTION_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_o, incr_o})); // R3
    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        disable_set |=> state_q == ST_IDLE); // R8
endmodule

// File: rtl/ewd_counter.sv
// Module: ewd_counter
// Holds the event count; loads all-ones minus period or increments by one.
// Reports the value it is about to take so the interrupt can be latched.
// Assumes load and incr are never active together.
module ewd_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             incr_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] nxt_o,
    output logic             upd_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Select the next count value.
    always_comb begin
        if (load_i)      nxt_o = ALL_ONES - period_i;
        else if (incr_i) nxt_o = cnt_q + 1'b1;
        else             nxt_o = cnt_q;
    end

    assign upd_o = load_i | incr_i;

    // Register the count; it holds whenever no action is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (upd_o) cnt_q <= nxt_o;
    end

    assign cnt_o = cnt_q;

    AST_INCR_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        incr_i |=> cnt_q == $past(cnt_q) + 1'b1); // R3
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i || incr_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/ewd_irq.sv
// Module: ewd_irq
// Sticky interrupt latch with write-one-to-clear; a set beats a clear.
// Assumes set and clear are synchronous single-cycle pulses.
module ewd_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    logic irq_q;

    // Latch the interrupt until software clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_q <= 1'b0;
        else if (set_i) irq_q <= 1'b1;
        else if (clr_i) irq_q <= 1'b0;
    end

    assign irq_o = irq_q;

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr_i) |=> irq_q); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_q); // R9
endmodule

// File: rtl/ext_event_wdt.sv
// Module: ext_event_wdt (top)
// External event counter watchdog: synchronizer, enable control, counter
// and interrupt latch. Assumes event_in holds each level for at least
// SYNC_STAGES system clocks.
module ext_event_wdt
    import ewd_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             event_in,
    input  logic [CNT_W-1:0] period_i,
    input  logic             enable_set,
    input  logic             disable_set,
    input  logic             irq_clr,
    output logic             irq_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TOP      = {{(CNT_W-1){1'b1}}, 1'b0};

    ewd_state_t       state;
    logic             rise;
    logic             load;
    logic             incr;
    logic             upd;
    logic [CNT_W-1:0] nxt;
    logic             irq_set;

    ewd_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (event_in),
        .rise_o  (rise)
    );

    ewd_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_set  (enable_set),
        .disable_set (disable_set),
        .rise_i      (rise),
        .cnt_i       (count_o),
        .state_o     (state),
        .load_o      (load),
        .incr_o      (incr)
    );

    ewd_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .incr_i   (incr),
        .period_i (period_i),
        .cnt_o    (count_o),
        .nxt_o    (nxt),
        .upd_o    (upd)
    );

    assign irq_set = upd && (nxt == TOP);

    ewd_irq irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_set),
        .clr_i (irq_clr),
        .irq_o (irq_o)
    );

    AST_FIRST_EDGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && rise && !enable_set && !disable_set)
        |=> count_o == ALL_ONES - $past(period_i)); // R2
    AST_TOP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && rise && count_o == TOP && !enable_set && !disable_set)
        |=> count_o == ALL_ONES - $past(period_i)); // R5
    AST_IRQ_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> count_o == TOP); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> $stable(count_o)); // R6
    AST_ARMED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !rise) |=> $stable(count_o)); // R7
endmodule

// File: tb/ext_event_wdt_tb_top.sv
module ext_event_wdt_tb_top;
    localparam int W = 32;
    localparam logic [W-1:0] ONES = {W{1'b1}};
    localparam logic [W-1:0] TOPV = ONES - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         event_in = 1'b0;
    logic [W-1:0] period_i = '0;
    logic         enable_set = 1'b0;
    logic         disable_set = 1'b0;
    logic         irq_clr = 1'b0;
    logic         irq_o;
    logic [W-1:0] count_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model state: 0 idle, 1 armed, 2 run
    int           m_st = 0;
    logic [W-1:0] m_cnt = '0;
    logic         m_irq = 1'b0;

    always #10 clk = ~clk;

    ext_event_wdt dut_i (
        .clk(clk), .rst_n(rst_n), .event_in(event_in), .period_i(period_i),
        .enable_set(enable_set), .disable_set(disable_set), .irq_clr(irq_clr),
        .irq_o(irq_o), .count_o(count_o)
    );

    function automatic logic [W-1:0] reload_val(input logic [W-1:0] p);
        return ONES - p;
    endfunction

    task automatic m_edge();
        if (m_st == 1) begin
            m_cnt = reload_val(period_i);
            m_st  = 2;
        end else if (m_st == 2) begin
            if (m_cnt >= TOPV) m_cnt = reload_val(period_i);
            else               m_cnt = m_cnt + 1;
        end else begin
            return;
        end
        if (m_cnt == TOPV) m_irq = 1'b1;
    endtask

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " count"}, count_o, m_cnt);
        chk({tag, " irq"}, {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, m_irq});
    endtask

    task automatic pulse(input int hi, input int lo);
        @(negedge clk) event_in = 1'b1;
        repeat (hi) @(negedge clk);
        event_in = 1'b0;
        repeat (lo) @(negedge clk);
        m_edge();
    endtask

    task automatic strobe(input logic en, input logic dis, input logic clr);
        @(negedge clk);
        enable_set = en; disable_set = dis; irq_clr = clr;
        @(negedge clk);
        enable_set = 1'b0; disable_set = 1'b0; irq_clr = 1'b0;
        if (dis)      m_st = 0;
        else if (en)  m_st = 1;
        if (clr) m_irq = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset");
        pulse(3, 3);
        chk_all("R1 ignored while idle after reset");

        period_i = 32'd3;
        strobe(1, 0, 0);
        repeat (4) @(negedge clk);
        chk_all("R2 armed holds before first edge");
        pulse(2, 3);
        chk("R2 first edge load", count_o, 32'hFFFF_FFFC);
        pulse(2, 3);
        chk("R3 increment", count_o, 32'hFFFF_FFFD);
        pulse(2, 3);
        chk("R4 reach top", count_o, 32'hFFFF_FFFE);
        chk("R4 irq set", {31'd0, irq_o}, 32'd1);
        pulse(2, 3);
        chk("R5 reload after top", count_o, 32'hFFFF_FFFC);
        chk("R9 irq sticky", {31'd0, irq_o}, 32'd1);
        strobe(0, 0, 1);
        chk("R9 irq cleared", {31'd0, irq_o}, 32'd0);

        strobe(0, 1, 0);
        pulse(2, 3);
        pulse(4, 3);
        chk_all("R6 disabled holds count");

        strobe(1, 0, 0);
        repeat (3) @(negedge clk);
        chk_all("R7 re-enable waits");
        pulse(2, 3);
        chk("R7 re-enable reload", count_o, 32'hFFFF_FFFC);
        pulse(2, 3);
        strobe(1, 0, 0);
        pulse(2, 3);
        chk("R7 enable while running restarts", count_o, 32'hFFFF_FFFC);

        period_i = 32'd1;
        strobe(1, 0, 0);
        pulse(2, 3);
        chk("R4 period one load at top", count_o, 32'hFFFF_FFFE);
        chk("R4 period one irq", {31'd0, irq_o}, 32'd1);
        strobe(0, 0, 1);
        chk_all("R9 clear after period one");

        strobe(1, 1, 0);
        pulse(2, 3);
        chk_all("R8 both strobes disable");

        period_i = 32'd5;
        strobe(1, 0, 0);
        pulse(2, 3);
        pulse(12, 3);
        chk("R10 long high counts once", count_o, 32'hFFFF_FFFB);
        pulse(2, 2);
        pulse(2, 3);
        chk("R10 minimum phases counted", count_o, 32'hFFFF_FFFD);

        // set and clear in the same cycle: clear held across the update edge
        @(negedge clk) event_in = 1'b1;
        repeat (2) @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk) irq_clr = 1'b0;
        event_in = 1'b0;
        repeat (3) @(negedge clk);
        m_edge();
        chk("R9 set wins over clear", {31'd0, irq_o}, 32'd1);
        chk_all("R4 top with simultaneous clear");

        // random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 6) begin
                pulse($urandom_range(2, 5), $urandom_range(3, 5));
                chk_all("R3 R5 random edge");
            end else if (op == 6) begin
                strobe(1, 0, 0);
                chk_all("R7 random enable");
            end else if (op == 7) begin
                strobe(0, 1, 0);
                chk_all("R6 random disable");
            end else if (op == 8) begin
                strobe(0, 0, 1);
                chk_all("R9 random clear");
            end else begin
                period_i = W'($urandom_range(1, 8));
                @(negedge clk);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule